// File: doc/BRIEF.md
# Hamming ECC Section Correction Checker

This block takes the 22-bit Hamming check code that was stored next to a 256-byte data section, together with the code that was just recalculated over the same data, and decides what happened to that section. It returns one of four outcomes: clean, one data bit to flip, damage in the code field itself, or damage too great to repair. When one data bit is repairable, the block also gives the byte offset and bit number that the surrounding logic must invert in its buffer.

Each code is split into two 11-bit halves. The low half holds eleven parity bits. The high half holds the eleven complementary parity bits. Both codes reach the block as three little-endian bytes on a 24-bit bus, and the two top bits of each are ignored. A check is started by a one-cycle `in_valid` strobe, and its result appears on the registered outputs one clock later.

A larger section made of several 256-byte parts is handled as consecutive checks. The last check of the section is marked with `in_last`. Together with that last result, the block reports the section verdict: the section fails if any part was bad, and otherwise it reports how many bits were repaired across all parts.

Top module: `ecc_section_checker`

## Requirements
- R1: After reset, `res_valid` and `sec_done` are low, and `res_status`, `res_byte`, `res_bit`, `sec_fail` and `sec_flips` are all zero.
- R2: `res_valid` is high exactly in the cycle after each `in_valid` cycle and is low otherwise.
- R3: When the XOR of the two codes (the syndrome) is zero, or when either code is all zeros, the status is 0 (clean).
- R4: When exactly one syndrome bit is set, the status is 2 (code field corrupt), and `res_byte` and `res_bit` are zero.
- R5: When exactly 11 syndrome bits are set and syndrome bit k differs from syndrome bit k+11 for every k from 0 to 10, the status is 1 (repairable). In that case `res_bit` equals syndrome bits [2:0] and `res_byte` equals syndrome bits [10:3].
- R6: Every other syndrome gives status 3 (multi-bit, not repairable), with `res_byte` and `res_bit` zero.
- R7: Bits [23:22] of both code inputs have no effect on any output.
- R8: A check with `in_last` high raises `sec_done` in the same cycle as its `res_valid`. If the section is good, `sec_flips` then holds the number of status-1 results in the section (saturating at 3). The section starts with the first check after the previous `in_last`.
- R9: If any check in the section returns status 2 or 3, then at `sec_done` the flag `sec_fail` is 1 and `sec_flips` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Start one 256-byte check |
| in_last | input | 1 | This check closes the section |
| code_stored | input | 24 | Stored code, three little-endian bytes |
| code_calc | input | 24 | Recalculated code, three little-endian bytes |
| res_valid | output | 1 | Per-check result valid |
| res_status | output | 2 | 0 clean, 1 repairable, 2 code field error, 3 uncorrectable |
| res_byte | output | 8 | Byte offset to flip |
| res_bit | output | 3 | Bit number to flip |
| sec_done | output | 1 | Section verdict valid |
| sec_fail | output | 1 | Section contains a bad part |
| sec_flips | output | 2 | Repaired bits in the section |

## Verification
The repairable case is the hardest outcome to reach. Random code pairs almost never give a syndrome of exactly 11 bits in which each bit is the complement of its partner in the other half. The bench therefore builds these syndromes on purpose, from a random address as the pair {~addr, addr}. It also builds near misses: two stacked single-bit errors, and an 11-bit syndrome whose halves overlap, which must be classed as uncorrectable. Section verdicts are driven with mixed sequences in which a bad first part is followed by a good or repaired second part.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;

  // Outcome of one 256-byte check
  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_FIXED    = 2'd1,
    ST_CODE_ERR = 2'd2,
    ST_MULTI    = 2'd3
  } ecc_status_e;

  // Set-bit count of a vector up to 32 bits wide
  function automatic logic [5:0] popcnt32(input logic [31:0] v);
    logic [5:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) n = n + {5'd0, v[i]};
    return n;
  endfunction

  // True when the status means the section cannot be trusted
  function automatic logic is_bad(input ecc_status_e s);
    return (s == ST_CODE_ERR) || (s == ST_MULTI);
  endfunction

endpackage

// File: rtl/ecc_syn_classify.sv
module ecc_syn_classify
  import ecc_chk_pkg::*;
#(
  parameter int HALF_W = 11,
  localparam int CODE_W = 2 * HALF_W,
  localparam int BYTE_W = HALF_W - 3
) (
  input  logic [CODE_W-1:0] stored_i,
  input  logic [CODE_W-1:0] calc_i,
  output ecc_status_e       status_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [2:0]        bit_o,
  output logic [CODE_W-1:0] syn_o
);

  logic [5:0]  syn_ones;
  logic        halves_comp;
  logic        any_zero;

  assign syn_o       = stored_i ^ calc_i;
  assign syn_ones    = popcnt32({{(32-CODE_W){1'b0}}, syn_o});
  assign halves_comp = &(syn_o[HALF_W-1:0] ^ syn_o[CODE_W-1:HALF_W]);
  assign any_zero    = (stored_i == '0) || (calc_i == '0);

  always_comb begin
    status_o = ST_MULTI;
    byte_o   = '0;
    bit_o    = '0;
    if (syn_o == '0 || any_zero) begin
      status_o = ST_CLEAN;
    end else if (syn_ones == 6'd1) begin
      status_o = ST_CODE_ERR;
    end else if (syn_ones == 6'(HALF_W) && halves_comp) begin
      status_o = ST_FIXED;
      bit_o    = syn_o[2:0];
      byte_o   = syn_o[HALF_W-1:3];
    end
  end

endmodule

// File: rtl/ecc_sec_accum.sv
module ecc_sec_accum
  import ecc_chk_pkg::*;
#(
  parameter int FLIP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_i,
  input  logic              last_i,
  input  ecc_status_e       status_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [FLIP_W-1:0] flips_o
);

  localparam logic [FLIP_W-1:0] FLIP_MAX = '1;

  logic              acc_fail;
  logic [FLIP_W-1:0] acc_flips;
  logic              cur_bad;
  logic              tot_fail;
  logic [FLIP_W-1:0] tot_flips;

  assign cur_bad   = is_bad(status_i);
  assign tot_fail  = acc_fail | cur_bad;
  assign tot_flips = (status_i == ST_FIXED && acc_flips != FLIP_MAX)
                     ? acc_flips + 1'b1 : acc_flips;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_fail  <= 1'b0;
      acc_flips <= '0;
      done_o    <= 1'b0;
      fail_o    <= 1'b0;
      flips_o   <= '0;
    end else begin
      done_o <= chk_i & last_i;
      if (chk_i) begin
        if (last_i) begin
          fail_o    <= tot_fail;
          flips_o   <= tot_fail ? '0 : tot_flips;
          acc_fail  <= 1'b0;
          acc_flips <= '0;
        end else begin
          acc_fail  <= tot_fail;
          acc_flips <= tot_flips;
        end
      end
    end
  end

  // R9
  bad_sets_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_i && last_i && cur_bad |=> done_o && fail_o && flips_o == '0);

endmodule

// File: rtl/ecc_section_checker.sv
module ecc_section_checker
  import ecc_chk_pkg::*;
#(
  parameter int HALF_W    = 11,
  parameter int CODE_IN_W = 24,
  parameter int FLIP_W    = 2,
  localparam int CODE_W   = 2 * HALF_W,
  localparam int BYTE_W   = HALF_W - 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_last,
  input  logic [CODE_IN_W-1:0] code_stored,
  input  logic [CODE_IN_W-1:0] code_calc,
  output logic                 res_valid,
  output logic [1:0]           res_status,
  output logic [BYTE_W-1:0]    res_byte,
  output logic [2:0]           res_bit,
  output logic                 sec_done,
  output logic                 sec_fail,
  output logic [FLIP_W-1:0]    sec_flips
);

  // Assembled codes: upper pad bits are dropped here
  logic [CODE_W-1:0] stored_code;
  logic [CODE_W-1:0] calc_code;
  logic [CODE_W-1:0] syn;
  ecc_status_e       cls_status;
  logic [BYTE_W-1:0] cls_byte;
  logic [2:0]        cls_bit;

  assign stored_code = code_stored[CODE_W-1:0];
  assign calc_code   = code_calc[CODE_W-1:0];

  ecc_syn_classify #(.HALF_W(HALF_W)) u_cls (
    .stored_i (stored_code),
    .calc_i   (calc_code),
    .status_o (cls_status),
    .byte_o   (cls_byte),
    .bit_o    (cls_bit),
    .syn_o    (syn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_status <= 2'd0;
      res_byte   <= '0;
      res_bit    <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_status <= cls_status;
        res_byte   <= cls_byte;
        res_bit    <= cls_bit;
      end
    end
  end

  ecc_sec_accum #(.FLIP_W(FLIP_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_i    (in_valid),
    .last_i   (in_last),
    .status_i (cls_status),
    .done_o   (sec_done),
    .fail_o   (sec_fail),
    .flips_o  (sec_flips)
  );

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
  // R3
  equal_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && syn == '0 |=> res_status == 2'd0);
  // R4
  single_bit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && stored_code != '0 && calc_code != '0 && $onehot0(syn) && syn != '0
    |=> res_status == 2'd2);
  // R6
  no_pos_unless_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_status != 2'd1 |-> res_byte == '0 && res_bit == '0);
  // R7
  pad_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && stored_code == calc_code &&
    code_stored[CODE_IN_W-1:CODE_W] != code_calc[CODE_IN_W-1:CODE_W]
    |=> res_status == 2'd0);
  // R8
  done_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_done |-> res_valid);

endmodule

// File: tb/ecc_section_checker_bench.sv
module ecc_section_checker_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic [23:0] code_stored = '0;
  logic [23:0] code_calc = '0;
  logic        res_valid;
  logic [1:0]  res_status;
  logic [7:0]  res_byte;
  logic [2:0]  res_bit;
  logic        sec_done;
  logic        sec_fail;
  logic [1:0]  sec_flips;

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 0;
  bit m_fail = 0;
  logic [1:0] m_flips = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_section_checker u_ecc_section_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .code_stored(code_stored), .code_calc(code_calc),
    .res_valid(res_valid), .res_status(res_status), .res_byte(res_byte),
    .res_bit(res_bit), .sec_done(sec_done), .sec_fail(sec_fail),
    .sec_flips(sec_flips)
  );

  // Expected {status, byte, bit} from the requirement text
  function automatic logic [12:0] model(input logic [23:0] s, input logic [23:0] c);
    logic [21:0] x;
    int ones;
    bit comp;
    x = s[21:0] ^ c[21:0];
    ones = 0;
    comp = 1;
    for (int i = 0; i < 22; i++) if (x[i]) ones++;
    for (int k = 0; k < 11; k++) if (x[k] == x[k+11]) comp = 0;
    if (x == 0 || s[21:0] == 0 || c[21:0] == 0) return 13'd0;
    if (ones == 1) return {2'd2, 11'd0};
    if (ones == 11 && comp) return {2'd1, x[10:0]};
    return {2'd3, 11'd0};
  endfunction

  function automatic logic [21:0] data_err(input logic [10:0] a);
    return {~a, a};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [23:0] s, input logic [23:0] c,
                         input bit last, input string req);
    logic [12:0] e;
    bit bad, tf;
    logic [1:0] tfl;
    @(negedge clk);
    code_stored = s; code_calc = c; in_last = last; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    e = model(s, c);
    check(req, {19'd0, res_status, res_byte, res_bit}, {19'd0, e});
    check("R2 res_valid after strobe", {31'd0, res_valid}, 32'd1);
    bad = (e[12:11] >= 2);
    tf  = m_fail | bad;
    tfl = (e[12:11] == 2'd1 && m_flips != 2'd3) ? m_flips + 2'd1 : m_flips;
    if (last) begin
      check("R8 sec_done on last", {31'd0, sec_done}, 32'd1);
      if (tf) check("R9 failing section", {29'd0, sec_fail, sec_flips}, {29'd0, 1'b1, 2'd0});
      else    check("R8 section flips", {29'd0, sec_fail, sec_flips}, {29'd0, 1'b0, tfl});
      m_fail = 0; m_flips = 0;
    end else begin
      check("R8 no sec_done mid-section", {31'd0, sec_done}, 32'd0);
      m_fail = tf; m_flips = tfl;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [23:0] s, c;
    logic [10:0] a;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 reset res_valid/sec_done", {30'd0, res_valid, sec_done}, 32'd0);
    check("R1 reset result fields", {19'd0, res_status, res_byte, res_bit}, 32'd0);
    check("R1 reset section fields", {29'd0, sec_fail, sec_flips}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 clean cases
    run_one(24'h12_3456, 24'h12_3456, 1, "R3 equal codes");
    run_one(24'h00_0000, 24'h2A_5A5A, 1, "R3 stored zero");
    run_one(24'h15_0F0F, 24'h00_0000, 1, "R3 calc zero");
    // R2: idle cycle drops valid
    @(negedge clk);
    check("R2 res_valid low when idle", {31'd0, res_valid}, 32'd0);
    // R4 code field damage
    run_one(24'h0A_AAAA, 24'h0A_AAAB, 1, "R4 lsb flipped");
    run_one(24'h0A_AAAA, 24'h0A_AAAA ^ 24'h20_0000, 1, "R4 msb flipped");
    // R5 single data bit
    run_one(24'h15_5555, 24'h15_5555 ^ {2'b0, data_err(11'h000)}, 1, "R5 byte0 bit0");
    run_one(24'h15_5555, 24'h15_5555 ^ {2'b0, data_err(11'h7FF)}, 1, "R5 byte255 bit7");
    run_one(24'h33_1234, 24'h33_1234 ^ {2'b0, data_err(11'h2A5)}, 1, "R5 mid position");
    // R6 uncorrectable
    run_one(24'h15_5555, 24'h15_5555 ^ {2'b0, data_err(11'h011) ^ data_err(11'h300)}, 1,
            "R6 two data bits");
    run_one(24'h15_5555, 24'h15_5555 ^ {2'b0, 11'h038, 11'h7F8}, 1, "R6 eleven bits overlapping");
    // R7 pad bits
    run_one(24'hC1_2345, 24'h01_2345, 1, "R7 pad differs only");
    run_one(24'h40_0000, 24'h80_0001, 1, "R7 pad with zero code");
    // R8/R9 two-part sections
    run_one(24'h15_5555, 24'h15_5555 ^ {2'b0, data_err(11'h123)}, 0, "R5 first half fix");
    run_one(24'h2A_AAAA, 24'h2A_AAAA ^ {2'b0, data_err(11'h456)}, 1, "R8 two fixes");
    run_one(24'h15_5555, 24'h15_5554 ^ 24'h00_0F00, 0, "R6 first half bad");
    run_one(24'h12_3456, 24'h12_3456, 1, "R9 bad then clean");
    run_one(24'h15_5555, 24'h15_5554, 0, "R4 first half code err");
    run_one(24'h15_5555, 24'h15_5555 ^ {2'b0, data_err(11'h001)}, 1, "R9 code err then fix");

    for (int i = 0; i < 400; i++) begin
      s = $urandom;
      a = 11'($urandom);
      case ($urandom % 5)
        0: c = s ^ {2'b0, data_err(a)};
        1: c = s ^ (24'd1 << ($urandom % 22));
        2: c = s ^ {2'b0, data_err(a) ^ data_err(11'($urandom))};
        3: c = {$urandom % 4, s[21:0]};
        default: c = $urandom;
      endcase
      c[23:22] = 2'($urandom);
      run_one(s, c, ($urandom % 2) == 1, "R5/R6 random pattern");
    end

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule